// File: doc/BRIEF.md
# Victim Line Buffer

This block sits next to a direct-mapped primary cache and holds a handful of lines that the primary cache recently threw out. Whenever the primary cache displaces a line to make room, it hands that line to the buffer. Whenever the primary cache misses, it asks the buffer for the missing line. The buffer compares the full block address against every slot at once, so any evicted line can sit in any slot.

On a buffer hit, the stored line goes back to the primary cache through the response port. In the same step, the line that currently occupies the requested primary set moves into the freed buffer slot, so the two lines trade places. On a buffer miss, the response reports the miss and a request to next-level memory is raised in the same cycle.

When a new eviction arrives and every slot is occupied, the least recently used slot is pushed out. If the line pushed out is dirty, it leaves on the writeback port toward the memory-side write queue. A clean line pushed out is simply dropped.

Top module: `victim_buffer`

## Requirements
- R1: After reset every slot is empty and `rsp_valid`, `mreq_valid` and `wb_valid` are low, so the first lookup of any address misses.
- R2: Each cycle with `lk_valid` high produces exactly one cycle of `rsp_valid` on the next clock edge, with `rsp_addr` equal to the looked-up address. Back-to-back lookups give back-to-back responses.
- R3: A response with `rsp_hit` low comes with `mreq_valid` high and `mreq_addr` equal to the looked-up address in the same cycle. A hit response never raises `mreq_valid`.
- R4: A line accepted through the eviction port is found by a later lookup of its address, which returns `rsp_hit`=1 with the same data and dirty flag.
- R5: On a hit with `lk_home_valid`=1, the home line (address, data, dirty) takes over the hit slot and becomes most recently used. The hit line is no longer held, so a later lookup of it misses, while a lookup of the home address hits.
- R6: On a hit with `lk_home_valid`=0, the hit slot becomes empty, and the next eviction fills it without displacing any line.
- R7: An eviction fills an empty slot while one exists. No writeback occurs unless all ENTRIES slots were occupied.
- R8: With all slots occupied, an eviction displaces the least recently used line. A line counts as used when it is inserted by eviction or written by a swap.
- R9: A displaced line with dirty=1 appears on `wb_valid`/`wb_addr`/`wb_data` one cycle after the eviction. A displaced line with dirty=0 produces no writeback, and a later lookup of it misses.
- R10: When `ev_valid` and `lk_valid` are high in the same cycle, the lookup is served and the eviction is dropped. A later lookup of the dropped address misses.
- R11: Matching uses every address bit. Two addresses that differ only in the top bit are held and returned separately, and at most one slot ever matches a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Primary cache hands over a displaced line |
| ev_addr | input | 28 | Block address of the displaced line |
| ev_data | input | 64 | Data of the displaced line |
| ev_dirty | input | 1 | Displaced line is modified |
| lk_valid | input | 1 | Primary miss lookup request |
| lk_addr | input | 28 | Block address being looked up |
| lk_home_valid | input | 1 | The primary set of the lookup holds a line that would be swapped out |
| lk_home_addr | input | 28 | Address of that primary line |
| lk_home_data | input | 64 | Data of that primary line |
| lk_home_dirty | input | 1 | Dirty flag of that primary line |
| rsp_valid | output | 1 | Lookup response |
| rsp_hit | output | 1 | Line was found in the buffer |
| rsp_addr | output | 28 | Address of the answered lookup |
| rsp_data | output | 64 | Line data moving into the primary cache on a hit |
| rsp_dirty | output | 1 | Dirty flag of the returned line |
| mreq_valid | output | 1 | Fetch request to next-level memory |
| mreq_addr | output | 28 | Address to fetch |
| wb_valid | output | 1 | Dirty line pushed out toward memory |
| wb_addr | output | 28 | Address of the pushed-out line |
| wb_data | output | 64 | Data of the pushed-out line |

## Verification
Some properties are checked on every cycle: the one-cycle response timing, the pairing between a miss response and the memory request, at most one slot matching a lookup, writebacks arising only from a full buffer and an eviction that was accepted, and occupancy stepping down on a swap with no home line and up on a fill into free space. What only the bench scenarios can show is content: which line replacement picks under a given use history, that swapped-in home lines return their own data and dirty flag, that dropped clean lines and ignored simultaneous evictions are really gone, and that addresses differing only in the top bit stay distinct. A recency-ordered reference list in the bench drives those expectations through directed and pseudo-random sequences.

// File: rtl/vb_pkg.sv
package vb_pkg;

    localparam int VB_ADDR_W  = 28;
    localparam int VB_DATA_W  = 64;
    localparam int VB_ENTRIES = 4;

    typedef logic [VB_ADDR_W-1:0] baddr_t;
    typedef logic [VB_DATA_W-1:0] bdata_t;

    typedef struct packed {
        logic   valid;
        logic   dirty;
        baddr_t addr;
        bdata_t data;
    } vline_t;

    function automatic vline_t make_line(logic v, logic d, baddr_t a, bdata_t x);
        vline_t l;
        l.valid = v;
        l.dirty = d;
        l.addr  = a;
        l.data  = x;
        return l;
    endfunction

endpackage

// File: rtl/vb_match.sv
module vb_match
    import vb_pkg::*;
#(
    parameter int N = VB_ENTRIES,
    localparam int IW = $clog2(N)
) (
    input  vline_t          slots [N],
    input  baddr_t          key,
    output logic [N-1:0]    hit_vec,
    output logic            hit,
    output logic [IW-1:0]   hit_idx
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = slots[g].valid && (slots[g].addr == key);
    end

    always_comb begin
        hit     = |hit_vec;
        hit_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) hit_idx = IW'(i);
        end
    end

endmodule

// File: rtl/vb_lru.sv
module vb_lru
    import vb_pkg::*;
#(
    parameter int N = VB_ENTRIES,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          touch,
    input  logic [IW-1:0] touch_idx,
    output logic [IW-1:0] lru_idx
);

    localparam logic [IW-1:0] OLDEST = IW'(N - 1);

    // age 0 = most recent; ages always form a permutation of 0..N-1
    logic [IW-1:0] age [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) age[i] <= IW'(i);
        end else if (touch) begin
            for (int i = 0; i < N; i++) begin
                if (IW'(i) == touch_idx)
                    age[i] <= '0;
                else if (age[i] < age[touch_idx])
                    age[i] <= age[i] + 1'b1;
            end
        end
    end

    always_comb begin
        lru_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (age[i] == OLDEST) lru_idx = IW'(i);
        end
    end

endmodule

// File: rtl/vb_fill_sel.sv
module vb_fill_sel
    import vb_pkg::*;
#(
    parameter int N = VB_ENTRIES,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  valid_vec,
    input  logic [IW-1:0] lru_idx,
    output logic [IW-1:0] fill_idx,
    output logic          full
);

    always_comb begin
        full     = &valid_vec;
        fill_idx = lru_idx;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) fill_idx = IW'(i);
        end
    end

endmodule

// File: rtl/victim_buffer.sv
module victim_buffer
    import vb_pkg::*;
#(
    parameter int ENTRIES = VB_ENTRIES,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ev_valid,
    input  logic [VB_ADDR_W-1:0] ev_addr,
    input  logic [VB_DATA_W-1:0] ev_data,
    input  logic                 ev_dirty,
    input  logic                 lk_valid,
    input  logic [VB_ADDR_W-1:0] lk_addr,
    input  logic                 lk_home_valid,
    input  logic [VB_ADDR_W-1:0] lk_home_addr,
    input  logic [VB_DATA_W-1:0] lk_home_data,
    input  logic                 lk_home_dirty,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic [VB_ADDR_W-1:0] rsp_addr,
    output logic [VB_DATA_W-1:0] rsp_data,
    output logic                 rsp_dirty,
    output logic                 mreq_valid,
    output logic [VB_ADDR_W-1:0] mreq_addr,
    output logic                 wb_valid,
    output logic [VB_ADDR_W-1:0] wb_addr,
    output logic [VB_DATA_W-1:0] wb_data
);

    vline_t              slots [ENTRIES];
    logic [ENTRIES-1:0]  valid_vec;
    logic [ENTRIES-1:0]  hit_vec;
    logic                hit;
    logic [IW-1:0]       hit_idx;
    logic [IW-1:0]       lru_idx;
    logic [IW-1:0]       fill_idx;
    logic                full;
    logic                touch;
    logic [IW-1:0]       touch_idx;
    logic                take_evict;
    vline_t              outgoing;
    vline_t              home_line;
    vline_t              new_line;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_vld
        assign valid_vec[g] = slots[g].valid;
    end

    vb_match #(.N(ENTRIES)) u_match (
        .slots   (slots),
        .key     (lk_addr),
        .hit_vec (hit_vec),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    vb_lru #(.N(ENTRIES)) u_lru (
        .clk       (clk),
        .rst       (rst),
        .touch     (touch),
        .touch_idx (touch_idx),
        .lru_idx   (lru_idx)
    );

    vb_fill_sel #(.N(ENTRIES)) u_fill (
        .valid_vec (valid_vec),
        .lru_idx   (lru_idx),
        .fill_idx  (fill_idx),
        .full      (full)
    );

    // lookups win the cycle; a concurrent eviction is not taken
    assign take_evict = ev_valid && !lk_valid;
    assign touch      = (lk_valid && hit && lk_home_valid) || take_evict;
    assign touch_idx  = (lk_valid && hit) ? hit_idx : fill_idx;
    assign outgoing   = slots[fill_idx];
    assign home_line  = make_line(lk_home_valid, lk_home_dirty, lk_home_addr, lk_home_data);
    assign new_line   = make_line(1'b1, ev_dirty, ev_addr, ev_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) slots[i] <= '0;
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_addr   <= '0;
            rsp_data   <= '0;
            rsp_dirty  <= 1'b0;
            mreq_valid <= 1'b0;
            mreq_addr  <= '0;
            wb_valid   <= 1'b0;
            wb_addr    <= '0;
            wb_data    <= '0;
        end else begin
            rsp_valid  <= 1'b0;
            mreq_valid <= 1'b0;
            wb_valid   <= 1'b0;
            if (lk_valid) begin
                rsp_valid <= 1'b1;
                rsp_addr  <= lk_addr;
                if (hit) begin
                    rsp_hit        <= 1'b1;
                    rsp_data       <= slots[hit_idx].data;
                    rsp_dirty      <= slots[hit_idx].dirty;
                    slots[hit_idx] <= home_line;
                end else begin
                    rsp_hit    <= 1'b0;
                    rsp_data   <= '0;
                    rsp_dirty  <= 1'b0;
                    mreq_valid <= 1'b1;
                    mreq_addr  <= lk_addr;
                end
            end else if (take_evict) begin
                slots[fill_idx] <= new_line;
                if (full && outgoing.dirty) begin
                    wb_valid <= 1'b1;
                    wb_addr  <= outgoing.addr;
                    wb_data  <= outgoing.data;
                end
            end
        end
    end

endmodule

// File: rtl/vb_checker.sv
module vb_checker #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         lk_valid,
    input logic         ev_valid,
    input logic         lk_home_valid,
    input logic         hit,
    input logic [N-1:0] hit_vec,
    input logic [N-1:0] valid_vec,
    input logic         rsp_valid,
    input logic         rsp_hit,
    input logic         mreq_valid,
    input logic         wb_valid
);

    assert_rsp_latency_R2: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);

    assert_rsp_origin_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(lk_valid));

    assert_miss_fetch_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> mreq_valid);

    assert_fetch_only_miss_R3: assert property (@(posedge clk) disable iff (rst)
        mreq_valid |-> (rsp_valid && !rsp_hit));

    assert_single_match_R11: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> $onehot0(hit_vec));

    assert_wb_when_full_R7: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> $past(&valid_vec));

    assert_wb_from_evict_R10: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> $past(ev_valid && !lk_valid));

    assert_free_on_bare_hit_R6: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && hit && !lk_home_valid) |=>
            ($countones(valid_vec) == $past($countones(valid_vec)) - 1));

    assert_fill_grows_R7: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && !lk_valid && !(&valid_vec)) |=>
            ($countones(valid_vec) == $past($countones(valid_vec)) + 1));

endmodule

bind victim_buffer vb_checker #(.N(ENTRIES)) u_vb_checker (
    .clk           (clk),
    .rst           (rst),
    .lk_valid      (lk_valid),
    .ev_valid      (ev_valid),
    .lk_home_valid (lk_home_valid),
    .hit           (hit),
    .hit_vec       (hit_vec),
    .valid_vec     (valid_vec),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .mreq_valid    (mreq_valid),
    .wb_valid      (wb_valid)
);

// File: tb/victim_buffer_test.sv
module victim_buffer_test;
    import vb_pkg::*;

    localparam int N = VB_ENTRIES;

    logic   clk = 1'b0;
    logic   rst = 1'b1;
    logic   ev_valid = 1'b0, ev_dirty = 1'b0;
    baddr_t ev_addr = '0;
    bdata_t ev_data = '0;
    logic   lk_valid = 1'b0, lk_home_valid = 1'b0, lk_home_dirty = 1'b0;
    baddr_t lk_addr = '0, lk_home_addr = '0;
    bdata_t lk_home_data = '0;
    logic   rsp_valid, rsp_hit, rsp_dirty, mreq_valid, wb_valid;
    baddr_t rsp_addr, mreq_addr, wb_addr;
    bdata_t rsp_data, wb_data;

    always #10 clk = ~clk;

    victim_buffer uut (
        .clk(clk), .rst(rst),
        .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_data(ev_data), .ev_dirty(ev_dirty),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_home_valid(lk_home_valid), .lk_home_addr(lk_home_addr),
        .lk_home_data(lk_home_data), .lk_home_dirty(lk_home_dirty),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr),
        .rsp_data(rsp_data), .rsp_dirty(rsp_dirty),
        .mreq_valid(mreq_valid), .mreq_addr(mreq_addr),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    typedef struct {
        logic   hit;
        baddr_t addr;
        bdata_t data;
        logic   dirty;
        int     due;
        string  tag;
    } exp_t;

    exp_t   rsp_q[$];
    exp_t   wb_q[$];
    vline_t mdl[$];          // reference: index 0 is most recently used
    int     checks = 0;
    int     fails  = 0;
    int     cyc    = 0;
    logic [31:0] lf = 32'h1234_5678;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int mfind(baddr_t a);
        for (int i = 0; i < mdl.size(); i++)
            if (mdl[i].addr == a) return i;
        return -1;
    endfunction

    function automatic logic [31:0] lfsr_next(logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    task automatic op(input logic ev, input baddr_t ea, input bdata_t ed, input logic edt,
                      input logic lk, input baddr_t la,
                      input logic hv, input baddr_t ha, input bdata_t hd, input logic hdt,
                      input string tag);
        exp_t e;
        ev_valid = ev; ev_addr = ea; ev_data = ed; ev_dirty = edt;
        lk_valid = lk; lk_addr = la;
        lk_home_valid = hv; lk_home_addr = ha; lk_home_data = hd; lk_home_dirty = hdt;
        e.due = cyc + 1;
        e.tag = tag;
        if (lk) begin
            int i;
            i = mfind(la);
            e.addr = la;
            e.hit  = (i >= 0);
            e.data = '0;
            e.dirty = 1'b0;
            if (i >= 0) begin
                e.data  = mdl[i].data;
                e.dirty = mdl[i].dirty;
                mdl.delete(i);
                if (hv) mdl.push_front(make_line(1'b1, hdt, ha, hd));
            end
            rsp_q.push_back(e);
        end else if (ev) begin
            if (mdl.size() == N) begin
                vline_t old;
                old = mdl.pop_back();
                if (old.dirty) begin
                    e.hit = 1'b1; e.addr = old.addr; e.data = old.data; e.dirty = 1'b1;
                    wb_q.push_back(e);
                end
            end
            mdl.push_front(make_line(1'b1, edt, ea, ed));
        end
        @(negedge clk);
    endtask

    task automatic evict(input baddr_t a, input bdata_t d, input logic dt, input string tag);
        op(1'b1, a, d, dt, 1'b0, '0, 1'b0, '0, '0, 1'b0, tag);
    endtask

    task automatic lookup(input baddr_t a, input logic hv, input baddr_t ha,
                          input bdata_t hd, input logic hdt, input string tag);
        op(1'b0, '0, '0, 1'b0, 1'b1, a, hv, ha, hd, hdt, tag);
    endtask

    task automatic idle(input int n);
        ev_valid = 1'b0; lk_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // monitor: compare responses and writebacks as they appear
    always @(negedge clk) begin
        if (!rst) begin
            while (rsp_q.size() > 0 && rsp_q[0].due < cyc) begin
                checks++; fails++;
                $display("FAIL %s response missing: actual=none expected addr=%h", rsp_q[0].tag, rsp_q[0].addr);
                void'(rsp_q.pop_front());
            end
            if (rsp_valid) begin
                checks++;
                if (rsp_q.size() == 0 || rsp_q[0].due != cyc) begin
                    fails++;
                    $display("FAIL R2 unexpected response: actual addr=%h expected none", rsp_addr);
                end else begin
                    exp_t e;
                    e = rsp_q.pop_front();
                    if (rsp_hit !== e.hit || rsp_addr !== e.addr || mreq_valid !== !e.hit ||
                        (!e.hit && mreq_addr !== e.addr) ||
                        (e.hit && (rsp_data !== e.data || rsp_dirty !== e.dirty))) begin
                        fails++;
                        $display("FAIL %s response: actual hit=%0b addr=%h data=%h dirty=%0b mreq=%0b/%h expected hit=%0b addr=%h data=%h dirty=%0b",
                                 e.tag, rsp_hit, rsp_addr, rsp_data, rsp_dirty, mreq_valid, mreq_addr,
                                 e.hit, e.addr, e.data, e.dirty);
                    end
                end
            end else if (mreq_valid) begin
                checks++; fails++;
                $display("FAIL R3 memory request without response: actual mreq=1 expected 0");
            end
            while (wb_q.size() > 0 && wb_q[0].due < cyc) begin
                checks++; fails++;
                $display("FAIL %s writeback missing: actual=none expected addr=%h", wb_q[0].tag, wb_q[0].addr);
                void'(wb_q.pop_front());
            end
            if (wb_valid) begin
                checks++;
                if (wb_q.size() == 0 || wb_q[0].due != cyc) begin
                    fails++;
                    $display("FAIL R9 unexpected writeback: actual addr=%h expected none", wb_addr);
                end else begin
                    exp_t e;
                    e = wb_q.pop_front();
                    if (wb_addr !== e.addr || wb_data !== e.data) begin
                        fails++;
                        $display("FAIL %s writeback: actual addr=%h data=%h expected addr=%h data=%h",
                                 e.tag, wb_addr, wb_data, e.addr, e.data);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        baddr_t top;
        top = baddr_t'(1) << (VB_ADDR_W - 1);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        checks++;
        if (rsp_valid !== 1'b0 || mreq_valid !== 1'b0 || wb_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset outputs: actual rsp=%0b mreq=%0b wb=%0b expected 0 0 0", rsp_valid, mreq_valid, wb_valid);
        end
        lookup(28'h100, 1'b0, '0, '0, 1'b0, "R1");
        idle(1);

        // R7, R4, R5: fill free slots, swap on hit
        evict(28'h0A1, 64'hD1D1, 1'b1, "R7");
        evict(28'h0A2, 64'hD2D2, 1'b0, "R7");
        evict(28'h0A3, 64'hD3D3, 1'b1, "R7");
        idle(1);
        lookup(28'h0A1, 1'b1, 28'h0B1, 64'hB1B1, 1'b0, "R4");
        lookup(28'h0B1, 1'b0, '0, '0, 1'b0, "R5");
        lookup(28'h0A1, 1'b0, '0, '0, 1'b0, "R5");
        idle(1);

        // R8, R9: overflow with dirty and clean victims
        evict(28'h0C1, 64'hC1, 1'b1, "R9");
        evict(28'h0C2, 64'hC2, 1'b0, "R9");
        evict(28'h0C3, 64'hC3, 1'b1, "R9");
        evict(28'h0C4, 64'hC4, 1'b0, "R9");
        evict(28'h0C5, 64'hC5, 1'b1, "R9");
        idle(1);
        lookup(28'h0C2, 1'b1, 28'h0E2, 64'hE2, 1'b1, "R8");
        evict(28'h0C6, 64'hC6, 1'b1, "R8");
        evict(28'h0C7, 64'hC7, 1'b0, "R8");
        lookup(28'h0E2, 1'b0, '0, '0, 1'b0, "R8");
        lookup(28'h0C1, 1'b0, '0, '0, 1'b0, "R9");
        idle(2);

        // R6: hit with no home line frees a slot
        evict(28'h0F1, 64'hF1, 1'b1, "R6");
        lookup(28'h0F1, 1'b0, '0, '0, 1'b0, "R6");
        evict(28'h0F2, 64'hF2, 1'b1, "R6");
        lookup(28'h0F2, 1'b0, '0, '0, 1'b0, "R6");
        idle(2);

        // R10: simultaneous eviction and lookup
        op(1'b1, 28'h0D9, 64'hD9, 1'b1, 1'b1, 28'h0C7, 1'b0, '0, '0, 1'b0, "R10");
        lookup(28'h0D9, 1'b0, '0, '0, 1'b0, "R10");
        idle(1);

        // R11: addresses differing only in top bit
        evict(28'h0055, 64'h55AA, 1'b0, "R11");
        evict(top | 28'h0055, 64'hAA55, 1'b1, "R11");
        lookup(top | 28'h0055, 1'b0, '0, '0, 1'b0, "R11");
        lookup(28'h0055, 1'b0, '0, '0, 1'b0, "R11");
        idle(1);

        // R2: back-to-back lookups
        evict(28'h0111, 64'h111, 1'b0, "R2");
        lookup(28'h0222, 1'b0, '0, '0, 1'b0, "R2");
        lookup(28'h0111, 1'b1, 28'h0333, 64'h333, 1'b1, "R2");
        lookup(28'h0333, 1'b1, 28'h0444, 64'h444, 1'b0, "R2");
        idle(2);

        // R8: pseudo-random mix against the reference list
        for (int k = 0; k < 400; k++) begin
            baddr_t a, h;
            int     kind;
            lf   = lfsr_next(lf);
            kind = int'(lf[1:0]);
            a    = baddr_t'({lf[4], 23'd0, lf[7:5]});
            h    = baddr_t'({lf[8], 23'd0, lf[11:9]});
            if (kind == 0 || kind == 3) begin
                if (mfind(a) < 0) evict(a, {lf, ~lf}, lf[12], "R8");
                else idle(1);
            end else if (kind == 1 && mfind(h) < 0 && h != a) begin
                lookup(a, 1'b1, h, {~lf, lf}, lf[13], "R8");
            end else begin
                lookup(a, 1'b0, '0, '0, 1'b0, "R8");
            end
        end
        idle(4);

        checks++;
        if (rsp_q.size() != 0 || wb_q.size() != 0) begin
            fails++;
            $display("FAIL R2 pending results: actual rsp=%0d wb=%0d expected 0 0", rsp_q.size(), wb_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule